// File: doc/BRIEF.md
# Address Breakpoint Trigger Unit

This unit watches a processor's 16-bit address bus. It raises an active-high breakpoint line when a qualified access hits a programmed address. An access is qualified when its address-valid strobe is asserted. The target address lives in two byte-wide registers, one for the upper half and one for the lower half. A control/status register holds three bits: an enable bit, a mode bit and a sticky hit flag. Software reaches all three registers through a small byte-wide port with separate write and read strobes and a 2-bit register select.

The mode bit sets how the output behaves:

- **Pulse mode:** a hit drives the line high for a fixed run of eight processor clock cycles. Because the count is in clock cycles, the pulse length scales with whatever clock rate the processor is running.
- **Level mode:** the line follows the hit flag. It stays high until software writes a one to that flag.

Clearing the enable bit drops the line at once and abandons any pulse in progress. The hit flag keeps its value when the enable bit is cleared.

Top module: `bkpt_trigger_unit`

## Requirements
- R1: Register select 0 reads and writes the address upper byte, select 1 the lower byte, and select 2 the control/status byte. In the control/status byte, bit 0 is enable, bit 1 is pulse mode, bit 7 is the hit flag, and the other bits read as 0. Select 3 reads 0 and ignores writes. reg_rdata shows the selected register in the same cycle that reg_rd is 1, and is 0 while reg_rd is 0. A write takes effect at the clock edge where reg_wr is 1.
- R2: A hit is counted only at an edge where addr_vld is 1, cpu_addr equals {upper, lower}, and enable is 1. brk_out is never 1 while enable is 0.
- R3: In pulse mode, brk_out is 1 for exactly 8 cycles, starting the cycle after the hit edge.
- R4: In level mode, brk_out is 1 from the cycle after a hit until the cycle after a write that clears the hit flag.
- R5: The hit flag is set by every counted hit, in either mode. A hit in the same cycle as a clearing write leaves the flag set.
- R6: Writing select 2 with bit 7 = 1 clears the hit flag. Writing bit 7 = 0 leaves the flag unchanged. Bits 0 and 1 are loaded on every select 2 write.
- R7: A write that clears enable makes brk_out 0 from the next cycle and stops any running pulse, so re-enabling does not resume it. The hit flag keeps its value.
- R8: A hit during a running pulse restarts the count at 8. The line stays high 8 cycles past the latest hit.
- R9: An asynchronous active-low reset clears both address bytes, all control bits, the hit flag and the pulse count. brk_out is 0 while in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cpu_addr | input | 16 | Processor address bus |
| addr_vld | input | 1 | Address-valid strobe, one cycle per access |
| reg_sel | input | 2 | Register select: 0 upper byte, 1 lower byte, 2 control/status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| brk_out | output | 1 | Breakpoint line, active high |

## Verification
Read data appears in the same cycle as the read strobe, so the bench samples reg_rdata 1 ns after it drives the strobe. Every register write and every hit takes effect at the following rising edge. The bench therefore drives inputs at falling edges and compares brk_out at the next falling edge, against a model that advances on the same rising edge. Pulse length, restart length, level hold and the one-cycle drop after disable are each measured by counting the cycles brk_out is high across consecutive falling-edge samples.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR_HI = 2'd0,
    SEL_ADDR_LO = 2'd1,
    SEL_CTRL    = 2'd2,
    SEL_NONE    = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_EN_BIT    = 0;
  localparam int unsigned CTRL_PULSE_BIT = 1;
  localparam int unsigned CTRL_STS_BIT   = 7;

  typedef struct packed {
    logic sts;
    logic pulse;
    logic en;
  } ctrl_t;

endpackage

// File: rtl/bkpt_regfile.sv
module bkpt_regfile
  import bkpt_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              hit,
  output logic [ADDR_W-1:0] bp_addr,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] reg_rdata
);

  localparam int unsigned HI_W = ADDR_W - DATA_W;

  logic [HI_W-1:0]   hi_q, hi_d;
  logic [DATA_W-1:0] lo_q, lo_d;
  ctrl_t             ctrl_q, ctrl_d;
  logic              wr_hi, wr_lo, wr_ctrl, ctrl_ce;
  logic [DATA_W-1:0] rd_mux;

  // write decode and next state
  always_comb begin
    wr_hi   = reg_wr && (reg_sel == SEL_ADDR_HI);
    wr_lo   = reg_wr && (reg_sel == SEL_ADDR_LO);
    wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);
    hi_d    = reg_wdata[HI_W-1:0];
    lo_d    = reg_wdata;
    ctrl_d  = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.en    = reg_wdata[CTRL_EN_BIT];
      ctrl_d.pulse = reg_wdata[CTRL_PULSE_BIT];
      if (reg_wdata[CTRL_STS_BIT]) ctrl_d.sts = 1'b0;
    end
    // a fresh hit outranks a clearing write
    if (hit) ctrl_d.sts = 1'b1;
    ctrl_ce = wr_ctrl || hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_hi)   hi_q   <= hi_d;
      if (wr_lo)   lo_q   <= lo_d;
      if (ctrl_ce) ctrl_q <= ctrl_d;
    end
  end

  // read path, same-cycle
  always_comb begin
    rd_mux = '0;
    unique case (reg_sel)
      SEL_ADDR_HI: rd_mux[HI_W-1:0] = hi_q;
      SEL_ADDR_LO: rd_mux = lo_q;
      SEL_CTRL: begin
        rd_mux[CTRL_EN_BIT]    = ctrl_q.en;
        rd_mux[CTRL_PULSE_BIT] = ctrl_q.pulse;
        rd_mux[CTRL_STS_BIT]   = ctrl_q.sts;
      end
      default: rd_mux = '0;
    endcase
    reg_rdata = reg_rd ? rd_mux : '0;
  end

  assign bp_addr = {hi_q, lo_q};
  assign ctrl    = ctrl_q;

endmodule

// File: rtl/bkpt_match.sv
module bkpt_match #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              addr_vld,
  input  logic [ADDR_W-1:0] bp_addr,
  input  logic              en,
  output logic              hit
);

  logic addr_eq;

  always_comb begin
    addr_eq = (cpu_addr == bp_addr);
    hit     = en && addr_vld && addr_eq;
  end

endmodule

// File: rtl/bkpt_pulse_gen.sv
module bkpt_pulse_gen #(
  parameter int unsigned PULSE_LEN = 8,
  parameter int unsigned CNT_W     = $clog2(PULSE_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pulse_mode,
  input  logic             sts,
  input  logic             hit,
  output logic [CNT_W-1:0] cnt,
  output logic             brk_out
);

  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce, running;

  always_comb begin
    running = (cnt_q != '0);
    cnt_d   = cnt_q;
    if (!en)                    cnt_d = '0;
    else if (hit && pulse_mode) cnt_d = LOAD_VAL;
    else if (running)           cnt_d = cnt_q - 1'b1;
    cnt_ce = !en || (hit && pulse_mode) || running;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign brk_out = en && (pulse_mode ? running : sts);
  assign cnt     = cnt_q;

endmodule

// File: rtl/bkpt_trigger_unit.sv
module bkpt_trigger_unit
  import bkpt_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PULSE_LEN = 8,
  localparam int unsigned CNT_W    = $clog2(PULSE_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              addr_vld,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              brk_out
);

  logic [ADDR_W-1:0] bp_addr;
  ctrl_t             ctrl_q;
  logic              hit;
  logic [CNT_W-1:0]  pulse_cnt;
  logic              ctrl_en, ctrl_pulse, ctrl_sts;

  bkpt_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .hit       (hit),
    .bp_addr   (bp_addr),
    .ctrl      (ctrl_q),
    .reg_rdata (reg_rdata)
  );

  assign ctrl_en    = ctrl_q.en;
  assign ctrl_pulse = ctrl_q.pulse;
  assign ctrl_sts   = ctrl_q.sts;

  bkpt_match #(.ADDR_W(ADDR_W)) u_match (
    .cpu_addr (cpu_addr),
    .addr_vld (addr_vld),
    .bp_addr  (bp_addr),
    .en       (ctrl_en),
    .hit      (hit)
  );

  bkpt_pulse_gen #(.PULSE_LEN(PULSE_LEN), .CNT_W(CNT_W)) u_pulse (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (ctrl_en),
    .pulse_mode (ctrl_pulse),
    .sts        (ctrl_sts),
    .hit        (hit),
    .cnt        (pulse_cnt),
    .brk_out    (brk_out)
  );

endmodule

// File: rtl/bkpt_trigger_chk.sv
module bkpt_trigger_chk #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PULSE_LEN = 8,
  parameter int unsigned CNT_W     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              addr_vld,
  input logic [1:0]        reg_sel,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              brk_out,
  input logic [ADDR_W-1:0] bp_addr,
  input logic              ctrl_en,
  input logic              ctrl_pulse,
  input logic              ctrl_sts,
  input logic [CNT_W-1:0]  pulse_cnt
);

  logic qual, ctl_wr;
  assign qual   = addr_vld && (cpu_addr == bp_addr) && ctrl_en;
  assign ctl_wr = reg_wr && (reg_sel == 2'd2);

  AST_OUT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_out |-> ctrl_en); // R2

  AST_FLAG_ONLY_FROM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_sts && !qual) |=> !ctrl_sts); // R2

  AST_PULSE_LOADS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && ctrl_pulse) |=> (pulse_cnt == CNT_W'(PULSE_LEN))); // R8

  AST_PULSE_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && pulse_cnt != '0 && !qual) |=> (pulse_cnt == CNT_W'($past(pulse_cnt) - 1'b1))); // R3

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_cnt <= CNT_W'(PULSE_LEN)); // R3

  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && !ctrl_pulse && ctrl_sts && !ctl_wr) |=> brk_out); // R4

  AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    qual |=> ctrl_sts); // R5

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && reg_wdata[7] && !qual) |=> !ctrl_sts); // R6

  AST_W0_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !reg_wdata[7] && ctrl_sts) |=> ctrl_sts); // R6

  AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !reg_wdata[0]) |=> (!brk_out && !ctrl_en)); // R7

endmodule

bind bkpt_trigger_unit bkpt_trigger_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_LEN(PULSE_LEN), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_addr   (cpu_addr),
  .addr_vld   (addr_vld),
  .reg_sel    (reg_sel),
  .reg_wr     (reg_wr),
  .reg_wdata  (reg_wdata),
  .brk_out    (brk_out),
  .bp_addr    (bp_addr),
  .ctrl_en    (ctrl_en),
  .ctrl_pulse (ctrl_pulse),
  .ctrl_sts   (ctrl_sts),
  .pulse_cnt  (pulse_cnt)
);

// File: tb/tb_bkpt_trigger_unit.sv
`timescale 1ns/1ps
module tb_bkpt_trigger_unit;

  localparam int CLK_NS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        addr_vld = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        brk_out;

  int n_chk = 0;
  int n_bad = 0;
  logic       last_out;
  logic [7:0] last_rd;

  always #(CLK_NS/2) clk = ~clk;

  bkpt_trigger_unit dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .addr_vld(addr_vld),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .brk_out(brk_out)
  );

  // reference model built from the requirements
  logic [7:0] m_hi, m_lo;
  logic       m_en, m_pm, m_sts;
  int         m_cnt;
  logic       m_hit;
  assign m_hit = m_en && addr_vld && (cpu_addr == {m_hi, m_lo});

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hi <= '0; m_lo <= '0; m_en <= 1'b0; m_pm <= 1'b0; m_sts <= 1'b0; m_cnt <= 0;
    end else begin
      if (reg_wr && reg_sel == 2'd0) m_hi <= reg_wdata;
      if (reg_wr && reg_sel == 2'd1) m_lo <= reg_wdata;
      if (reg_wr && reg_sel == 2'd2) begin
        m_en <= reg_wdata[0];
        m_pm <= reg_wdata[1];
      end
      if (m_hit) m_sts <= 1'b1;
      else if (reg_wr && reg_sel == 2'd2 && reg_wdata[7]) m_sts <= 1'b0;
      if (!m_en) m_cnt <= 0;
      else if (m_hit && m_pm) m_cnt <= 8;
      else if (m_cnt != 0) m_cnt <= m_cnt - 1;
    end
  end

  function automatic logic exp_out();
    return m_en && (m_pm ? (m_cnt != 0) : m_sts);
  endfunction

  function automatic logic [7:0] exp_rd(input logic [1:0] s, input logic r);
    if (!r) return 8'h00;
    case (s)
      2'd0: return m_hi;
      2'd1: return m_lo;
      2'd2: return {m_sts, 5'b0, m_pm, m_en};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] a, input logic v, input logic [1:0] s,
                      input logic w, input logic r, input logic [7:0] d);
    string tag;
    @(negedge clk);
    last_out = brk_out;
    tag = !m_en ? "R2" : (m_pm ? "R3" : "R4");
    chk(tag, "brk_out vs model", {15'b0, brk_out}, {15'b0, exp_out()});
    cpu_addr = a; addr_vld = v; reg_sel = s; reg_wr = w; reg_rd = r; reg_wdata = d;
    #1;
    last_rd = reg_rdata;
    chk("R1", "reg_rdata vs model", {8'b0, reg_rdata}, {8'b0, exp_rd(s, r)});
  endtask

  task automatic idle();                          step(16'h0, 1'b0, 2'd0, 1'b0, 1'b0, 8'h0); endtask
  task automatic wreg(input logic [1:0] s, input logic [7:0] d); step(16'h0, 1'b0, s, 1'b1, 1'b0, d); endtask
  task automatic rreg(input logic [1:0] s);        step(16'h0, 1'b0, s, 1'b0, 1'b1, 8'h0); endtask
  task automatic hitc();                          step(16'hA53C, 1'b1, 2'd0, 1'b0, 1'b0, 8'h0); endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    int hc;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R9 reset state
    for (int s = 0; s < 4; s++) begin
      rreg(2'(s));
      chk("R9", "reset register", {8'b0, last_rd}, 16'h0);
    end
    idle(); chk("R9", "reset brk_out", {15'b0, last_out}, 16'h0);

    // R1 map and readback
    wreg(2'd0, 8'hA5); wreg(2'd1, 8'h3C);
    // R2 disabled: a matching access leaves flag clear
    hitc(); idle(); rreg(2'd2);
    chk("R2", "flag with enable off", {8'b0, last_rd}, 16'h0);
    wreg(2'd3, 8'hFF); rreg(2'd3);
    chk("R1", "select 3 reads zero", {8'b0, last_rd}, 16'h0);
    wreg(2'd2, 8'h03);
    rreg(2'd0); chk("R1", "upper byte", {8'b0, last_rd}, 16'h00A5);
    rreg(2'd1); chk("R1", "lower byte", {8'b0, last_rd}, 16'h003C);
    rreg(2'd2); chk("R1", "control byte", {8'b0, last_rd}, 16'h0003);
    step(16'h0, 1'b0, 2'd0, 1'b0, 1'b0, 8'h0);
    chk("R1", "rdata without strobe", {8'b0, last_rd}, 16'h0);

    // R2 strobe low or address off by one: no hit
    step(16'hA53C, 1'b0, 2'd0, 1'b0, 1'b0, 8'h0);
    step(16'hA53D, 1'b1, 2'd0, 1'b0, 1'b0, 8'h0);
    idle(); chk("R2", "no output without hit", {15'b0, last_out}, 16'h0);
    rreg(2'd2); chk("R2", "no flag without hit", {8'b0, last_rd}, 16'h0003);

    // R3 pulse length
    hitc(); hc = 0;
    for (int i = 0; i < 12; i++) begin idle(); hc += last_out; end
    chk("R3", "pulse length", 16'(hc), 16'd8);
    rreg(2'd2); chk("R5", "flag set in pulse mode", {8'b0, last_rd}, 16'h0083);

    // R6 write-zero keeps, write-one clears
    wreg(2'd2, 8'h03); rreg(2'd2);
    chk("R6", "write 0 keeps flag", {8'b0, last_rd}, 16'h0083);
    wreg(2'd2, 8'h83); rreg(2'd2);
    chk("R6", "write 1 clears flag", {8'b0, last_rd}, 16'h0003);

    // R8 retrigger
    hitc(); hc = 0;
    idle(); hc += last_out; idle(); hc += last_out;
    hitc(); hc += last_out;
    for (int i = 0; i < 14; i++) begin idle(); hc += last_out; end
    chk("R8", "retriggered length", 16'(hc), 16'd11);

    // R7 disable mid-pulse
    wreg(2'd2, 8'h83); hitc(); idle(); idle();
    chk("R7", "pulse running", {15'b0, last_out}, 16'h1);
    wreg(2'd2, 8'h02); idle();
    chk("R7", "drop after disable", {15'b0, last_out}, 16'h0);
    rreg(2'd2); chk("R7", "flag kept on disable", {8'b0, last_rd}, 16'h0082);
    wreg(2'd2, 8'h03); idle(); idle();
    chk("R7", "pulse not resumed", {15'b0, last_out}, 16'h0);

    // R4 level mode
    wreg(2'd2, 8'h81); hitc(); hc = 0;
    for (int i = 0; i < 20; i++) begin idle(); hc += last_out; end
    chk("R4", "level held", 16'(hc), 16'd20);
    wreg(2'd2, 8'h81); idle();
    chk("R4", "level released by W1C", {15'b0, last_out}, 16'h0);
    rreg(2'd2); chk("R4", "flag cleared", {8'b0, last_rd}, 16'h0001);

    // R5 hit collides with clearing write
    step(16'hA53C, 1'b1, 2'd2, 1'b1, 1'b0, 8'h81); idle();
    chk("R5", "hit wins over clear", {15'b0, last_out}, 16'h1);
    rreg(2'd2); chk("R5", "flag after collision", {8'b0, last_rd}, 16'h0081);

    // constrained random against the model
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a; logic [1:0] s; logic w; logic [7:0] d;
      a = ($urandom % 3 == 0) ? {m_hi, m_lo} : 16'($urandom);
      s = 2'($urandom);
      w = ($urandom % 10 == 0);
      d = 8'($urandom);
      if (s == 2'd2) d[0] = ($urandom % 6 != 0);
      if (s != 2'd2 && ($urandom % 2 == 0)) w = 1'b0;
      step(a, ($urandom % 4 != 0), s, w, 1'($urandom), d);
    end
    idle();
    summary();
  end

endmodule